// File: doc/BRIEF.md
# Double-Buffered Gamma Lookup Controller

This block keeps a gamma lookup table for each colour channel (red, green, blue) in two banks, A and B. Software fills one bank through a small register port while the pixel path reads from the other. The host chooses which bank receives writes and which channels a write touches through a 3-bit channel mask. It then sets a start index and streams data words; the index advances by itself after every accepted word, so one stream can fill any subset of the three tables.

The mode and the active bank are requested through a control register, but the pixel path only adopts them on a one-cycle frame-start pulse. A picture therefore never mixes two tables. In bypass mode each pixel code passes straight through. In lookup mode the upper bits of each channel's code address the active bank. Both paths have one cycle of latency. A status register reports the mode and bank actually in effect.

Top module: `gamma_lut_dbuf`

## Requirements
- R1: After reset the pending and current mode are bypass and the bank is A. The channel mask reads 7, the write target is bank A, the index reads 0, and the pixel outputs are 0.
- R2: A write to the data register (address 3) stores the word at the current index of the target bank. It is stored only in the channels whose mask bit is set: bit 2 red, bit 1 green, bit 0 blue. The index then increases by one, including when the mask is 0.
- R3: A write to the index register (address 2) loads the write index with the low IW+1 bits of the word. Reading address 2 returns the index.
- R4: An accepted data write at index ENTRIES-1 moves the index to 0.
- R5: While the index is ENTRIES or more, data writes change no table entry and leave the index unchanged.
- R6: The configuration register (address 1) holds the channel mask in bits [2:0] and the write target bank in bit 3 (0 = A, 1 = B). Both read back.
- R7: The control register (address 0) holds the requested mode in bits [1:0] and the requested bank in bit 2, and it reads back. Neither the status nor the pixel path changes until a frame_start pulse, which copies both into the current state.
- R8: Only requested mode 2 selects table lookup. Any other value takes effect as bypass and is reported as 0.
- R9: The status register (address 4) shows the current mode in bits [1:0]. Bit 2 shows the active bank in lookup mode and reads 0 in bypass.
- R10: In bypass, each output equals its channel's input code from one cycle earlier.
- R11: In lookup mode, each output is the active bank's entry for that channel at index code[DW-1 -: IW], one cycle after the code is presented.
- R12: Loading the inactive bank does not change what the active bank returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data for reg_addr (combinational) |
| frame_start | input | 1 | One-cycle pulse at the start of a frame |
| pix_r_in | input | DW | Red input code |
| pix_g_in | input | DW | Green input code |
| pix_b_in | input | DW | Blue input code |
| pix_r_out | output | DW | Red output |
| pix_g_out | output | DW | Green output |
| pix_b_out | output | DW | Blue output |

## Verification
The vector walk loads different values into each channel of the same entry using masks 4 and 1 after a full mask-7 load. A lookup then returns three distinct words, which separates mask decoding from channel wiring and reveals a swapped channel. Bank B is filled while bank A is active, and lookups are checked before and after the swap pulse, so an immediate swap and a wrong write target show up differently. The wrap from the last entry, an out-of-range index whose ignored write would otherwise land on entry 0, a non-2 mode request and a zero mask each have a lookup that is affected only if that one corner is wrong.

// File: rtl/gamma_lut_pkg.sv
package gamma_lut_pkg;
  localparam logic [1:0] MODE_BYPASS = 2'd0;
  localparam logic [1:0] MODE_LUT    = 2'd2;

  localparam logic [2:0] ADR_CTRL   = 3'd0;
  localparam logic [2:0] ADR_CFG    = 3'd1;
  localparam logic [2:0] ADR_INDEX  = 3'd2;
  localparam logic [2:0] ADR_DATA   = 3'd3;
  localparam logic [2:0] ADR_STATUS = 3'd4;

  // channel 0 = red (mask bit 2), 1 = green (bit 1), 2 = blue (bit 0)
  function automatic logic chan_enabled(input logic [2:0] mask, input int ch);
    return mask[2-ch];
  endfunction

  function automatic logic [1:0] effective_mode(input logic [1:0] req);
    return (req == MODE_LUT) ? MODE_LUT : MODE_BYPASS;
  endfunction
endpackage

// File: rtl/glut_regs.sv
module glut_regs
  import gamma_lut_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int DW      = 10
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         reg_we,
  input  logic [2:0]                   reg_addr,
  input  logic [DW-1:0]                reg_wdata,
  output logic [DW-1:0]                reg_rdata,
  input  logic                         frame_start,
  output logic                         wr_go,
  output logic [$clog2(ENTRIES)-1:0]   wr_idx,
  output logic                         wr_bank,
  output logic [2:0]                   wr_mask,
  output logic [$clog2(ENTRIES):0]     idx_ptr,
  output logic [1:0]                   req_mode,
  output logic                         req_bank,
  output logic [1:0]                   cur_mode,
  output logic                         cur_bank
);
  localparam int IW = $clog2(ENTRIES);
  localparam int PW = IW + 1;

  logic in_range;
  logic data_wr;

  function automatic logic [PW-1:0] advance(input logic [PW-1:0] p);
    return (p == PW'(ENTRIES - 1)) ? '0 : p + 1'b1;
  endfunction

  assign in_range = idx_ptr < PW'(ENTRIES);
  assign data_wr  = reg_we && (reg_addr == ADR_DATA);
  assign wr_go    = data_wr && in_range;
  assign wr_idx   = idx_ptr[IW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_mode <= MODE_BYPASS;
      req_bank <= 1'b0;
      wr_mask  <= 3'b111;
      wr_bank  <= 1'b0;
      idx_ptr  <= '0;
      cur_mode <= MODE_BYPASS;
      cur_bank <= 1'b0;
    end else begin
      if (reg_we) begin
        case (reg_addr)
          ADR_CTRL: begin
            req_mode <= reg_wdata[1:0];
            req_bank <= reg_wdata[2];
          end
          ADR_CFG: begin
            wr_mask <= reg_wdata[2:0];
            wr_bank <= reg_wdata[3];
          end
          ADR_INDEX: idx_ptr <= reg_wdata[PW-1:0];
          ADR_DATA:  if (in_range) idx_ptr <= advance(idx_ptr);
          default: ;
        endcase
      end
      if (frame_start) begin
        cur_mode <= effective_mode(req_mode);
        cur_bank <= req_bank;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADR_CTRL:   reg_rdata = DW'({req_bank, req_mode});
      ADR_CFG:    reg_rdata = DW'({wr_bank, wr_mask});
      ADR_INDEX:  reg_rdata = DW'(idx_ptr);
      ADR_STATUS: reg_rdata = DW'({(cur_mode == MODE_LUT) & cur_bank, cur_mode});
      default:    reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/glut_chan_ram.sv
module glut_chan_ram #(
  parameter int ENTRIES = 16,
  parameter int DW      = 10
) (
  input  logic                       clk,
  input  logic                       we,
  input  logic                       wbank,
  input  logic [$clog2(ENTRIES)-1:0] widx,
  input  logic [DW-1:0]              wdata,
  input  logic                       rbank,
  input  logic [$clog2(ENTRIES)-1:0] ridx,
  output logic [DW-1:0]              rdata
);
  localparam int IW    = $clog2(ENTRIES);
  localparam int DEPTH = 2 * ENTRIES;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[{wbank, widx}] <= wdata;
    rdata <= mem[{rbank, ridx}];
  end
endmodule

// File: rtl/gamma_lut_dbuf.sv
module gamma_lut_dbuf
  import gamma_lut_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int DW      = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [2:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          frame_start,
  input  logic [DW-1:0] pix_r_in,
  input  logic [DW-1:0] pix_g_in,
  input  logic [DW-1:0] pix_b_in,
  output logic [DW-1:0] pix_r_out,
  output logic [DW-1:0] pix_g_out,
  output logic [DW-1:0] pix_b_out
);
  localparam int IW = $clog2(ENTRIES);
  localparam int PW = IW + 1;

  // named internal events for the checker
  logic          wr_go;
  logic [IW-1:0] wr_idx;
  logic          wr_bank;
  logic [2:0]    wr_mask;
  logic [PW-1:0] idx_ptr;
  logic [1:0]    req_mode;
  logic          req_bank;
  logic [1:0]    cur_mode;
  logic          cur_bank;
  logic          bypass_now;
  logic          bypass_q;

  logic [DW-1:0] pin   [3];
  logic [DW-1:0] code_q[3];
  logic [DW-1:0] lut_q [3];
  logic [DW-1:0] pout  [3];

  glut_regs #(.ENTRIES(ENTRIES), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .frame_start(frame_start),
    .wr_go(wr_go), .wr_idx(wr_idx), .wr_bank(wr_bank), .wr_mask(wr_mask),
    .idx_ptr(idx_ptr), .req_mode(req_mode), .req_bank(req_bank),
    .cur_mode(cur_mode), .cur_bank(cur_bank)
  );

  assign bypass_now = (cur_mode != MODE_LUT);
  assign pin[0] = pix_r_in;
  assign pin[1] = pix_g_in;
  assign pin[2] = pix_b_in;

  for (genvar ch = 0; ch < 3; ch++) begin : g_chan
    glut_chan_ram #(.ENTRIES(ENTRIES), .DW(DW)) u_ram (
      .clk(clk),
      .we(wr_go && chan_enabled(wr_mask, ch)),
      .wbank(wr_bank), .widx(wr_idx), .wdata(reg_wdata),
      .rbank(cur_bank), .ridx(pin[ch][DW-1 -: IW]),
      .rdata(lut_q[ch])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) code_q[ch] <= '0;
      else        code_q[ch] <= pin[ch];
    end

    assign pout[ch] = bypass_q ? code_q[ch] : lut_q[ch];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bypass_q <= 1'b1;
    else        bypass_q <= bypass_now;
  end

  assign pix_r_out = pout[0];
  assign pix_g_out = pout[1];
  assign pix_b_out = pout[2];
endmodule

// File: rtl/glut_checker.sv
module glut_checker
  import gamma_lut_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int DW      = 10,
  parameter int PW      = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_we,
  input logic [2:0]    reg_addr,
  input logic [PW-1:0] idx_ptr,
  input logic          frame_start,
  input logic [1:0]    req_mode,
  input logic          req_bank,
  input logic [1:0]    cur_mode,
  input logic          cur_bank,
  input logic          bypass_now,
  input logic [DW-1:0] pix_r_in,
  input logic [DW-1:0] pix_r_out,
  input logic [DW-1:0] pix_b_in,
  input logic [DW-1:0] pix_b_out
);
  logic data_wr;
  assign data_wr = reg_we && (reg_addr == ADR_DATA);

  assert_index_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && idx_ptr < PW'(ENTRIES - 1)) |=> idx_ptr == $past(idx_ptr) + 1'b1);

  assert_index_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && idx_ptr == PW'(ENTRIES - 1)) |=> idx_ptr == '0);

  assert_out_of_range_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && idx_ptr >= PW'(ENTRIES)) |=> $stable(idx_ptr));

  assert_no_early_swap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> ($stable(cur_mode) && $stable(cur_bank)));

  assert_swap_on_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (cur_bank == $past(req_bank)));

  assert_mode_norm_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (cur_mode == (($past(req_mode) == MODE_LUT) ? MODE_LUT : MODE_BYPASS)));

  assert_bypass_pass_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bypass_now |=> (pix_r_out == $past(pix_r_in) && pix_b_out == $past(pix_b_in)));
endmodule

bind gamma_lut_dbuf glut_checker #(.ENTRIES(ENTRIES), .DW(DW), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .idx_ptr(idx_ptr), .frame_start(frame_start), .req_mode(req_mode),
  .req_bank(req_bank), .cur_mode(cur_mode), .cur_bank(cur_bank),
  .bypass_now(bypass_now), .pix_r_in(pix_r_in), .pix_r_out(pix_r_out),
  .pix_b_in(pix_b_in), .pix_b_out(pix_b_out)
);

// File: tb/tb_gamma_lut_dbuf.sv
module tb_gamma_lut_dbuf;
  localparam int ENTRIES = 16;
  localparam int DW      = 10;

  localparam logic [1:0] K_WR = 2'd0, K_RD = 2'd1, K_FR = 2'd2, K_PX = 2'd3;
  localparam logic [2:0] A_CTRL = 3'd0, A_CFG = 3'd1, A_IDX = 3'd2, A_DAT = 3'd3, A_ST = 3'd4;

  // vector: kind[50:49] addr[48:46] arg[45:30] expect[29:0]
  function automatic logic [50:0] wr(input logic [2:0] a, input logic [15:0] d);
    return {K_WR, a, d, 30'd0};
  endfunction
  function automatic logic [50:0] rd(input logic [2:0] a, input logic [9:0] e);
    return {K_RD, a, 16'd0, 20'd0, e};
  endfunction
  function automatic logic [50:0] fr();
    return {K_FR, 3'd0, 16'd0, 30'd0};
  endfunction
  function automatic logic [50:0] px(input logic [9:0] c, input logic [9:0] r,
                                     input logic [9:0] g, input logic [9:0] b);
    return {K_PX, 3'd0, 6'd0, c, r, g, b};
  endfunction

  localparam int NV = 57;
  localparam logic [50:0] VEC [NV] = '{
    rd(A_ST, 10'h0),                                           // R1
    rd(A_IDX, 10'h0),                                          // R1
    rd(A_CFG, 10'h7),                                          // R1
    px(10'h155, 10'h155, 10'h155, 10'h155),                    // R10
    wr(A_CFG, 16'h7), wr(A_IDX, 16'h0),
    wr(A_DAT, 16'h100), wr(A_DAT, 16'h101),
    rd(A_IDX, 10'h2),                                          // R2 R3
    wr(A_CFG, 16'h4), wr(A_IDX, 16'h1), wr(A_DAT, 16'h2AA),    // red only
    wr(A_CFG, 16'h1), wr(A_IDX, 16'h1), wr(A_DAT, 16'h033),    // blue only
    wr(A_CTRL, 16'h2),
    rd(A_ST, 10'h0),                                           // R7 deferred
    px(10'h040, 10'h040, 10'h040, 10'h040),                    // R7 still bypass
    fr(),
    rd(A_ST, 10'h2),                                           // R9
    px(10'h040, 10'h2AA, 10'h101, 10'h033),                    // R2 R11
    px(10'h07F, 10'h2AA, 10'h101, 10'h033),                    // R11
    px(10'h000, 10'h100, 10'h100, 10'h100),                    // R11
    wr(A_CFG, 16'hF), wr(A_IDX, 16'h0), wr(A_DAT, 16'h3FF),
    px(10'h000, 10'h100, 10'h100, 10'h100),                    // R12
    wr(A_CTRL, 16'h6),
    rd(A_CTRL, 10'h6),                                         // R7
    px(10'h000, 10'h100, 10'h100, 10'h100),                    // R7 no early swap
    fr(),
    rd(A_ST, 10'h6),                                           // R9
    px(10'h000, 10'h3FF, 10'h3FF, 10'h3FF),                    // R6 R7
    wr(A_IDX, 16'hF), wr(A_DAT, 16'h011),
    rd(A_IDX, 10'h0),                                          // R4
    wr(A_DAT, 16'h022),
    px(10'h3C0, 10'h011, 10'h011, 10'h011),                    // R4
    px(10'h000, 10'h022, 10'h022, 10'h022),                    // R4
    wr(A_IDX, 16'h10),
    rd(A_IDX, 10'h10),                                         // R3
    wr(A_DAT, 16'h155),
    rd(A_IDX, 10'h10),                                         // R5
    px(10'h000, 10'h022, 10'h022, 10'h022),                    // R5
    wr(A_CTRL, 16'h7), fr(),
    rd(A_ST, 10'h0),                                           // R8
    px(10'h123, 10'h123, 10'h123, 10'h123),                    // R8 R10
    wr(A_CTRL, 16'h2), fr(),
    rd(A_ST, 10'h2),                                           // R9
    px(10'h000, 10'h100, 10'h100, 10'h100),                    // R11
    wr(A_CFG, 16'h0), wr(A_IDX, 16'h0), wr(A_DAT, 16'h3AB),
    rd(A_IDX, 10'h1),                                          // R2 zero mask advances
    px(10'h000, 10'h100, 10'h100, 10'h100)                     // R2 zero mask no store
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_we = 1'b0;
  logic [2:0]    reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic          frame_start = 1'b0;
  logic [DW-1:0] pr = '0, pg = '0, pb = '0;
  logic [DW-1:0] qr, qg, qb;
  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  gamma_lut_dbuf #(.ENTRIES(ENTRIES), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .frame_start(frame_start),
    .pix_r_in(pr), .pix_g_in(pg), .pix_b_in(pb),
    .pix_r_out(qr), .pix_g_out(qg), .pix_b_out(qb)
  );

  task automatic check(input string req, input logic [29:0] act, input logic [29:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_vec(input int i, input logic [50:0] v);
    logic [1:0]  kind = v[50:49];
    logic [2:0]  a    = v[48:46];
    logic [15:0] arg  = v[45:30];
    logic [29:0] e    = v[29:0];
    case (kind)
      K_WR: begin
        @(negedge clk); reg_addr = a; reg_wdata = arg[DW-1:0]; reg_we = 1'b1;
        @(negedge clk); reg_we = 1'b0;
      end
      K_RD: begin
        @(negedge clk); reg_addr = a; #1;
        check($sformatf("vector %0d register read (R1-R9 per comment)", i), {20'd0, reg_rdata}, e);
      end
      K_FR: begin
        @(negedge clk); frame_start = 1'b1;
        @(negedge clk); frame_start = 1'b0;
      end
      default: begin
        @(negedge clk); pr = arg[DW-1:0]; pg = arg[DW-1:0]; pb = arg[DW-1:0];
        @(negedge clk);
        check($sformatf("vector %0d pixel path (R10/R11 per comment)", i), {qr, qg, qb}, e);
      end
    endcase
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1;
    check("R1 outputs in reset", {qr, qg, qb}, 30'd0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) run_vec(i, VEC[i]);

    // R10: back-to-back bypass codes on distinct channels
    run_vec(100, wr(A_CTRL, 16'h0));
    run_vec(101, fr());
    @(negedge clk); pr = 10'h3A5; pg = 10'h05A; pb = 10'h2C3;
    @(negedge clk);
    check("R10 distinct channels", {qr, qg, qb}, {10'h3A5, 10'h05A, 10'h2C3});
    pr = 10'h001; pg = 10'h3FE; pb = 10'h200;
    @(negedge clk);
    check("R10 next cycle", {qr, qg, qb}, {10'h001, 10'h3FE, 10'h200});

    // R1: reset in the middle of operation
    run_vec(102, wr(A_CTRL, 16'h6));
    run_vec(103, fr());
    run_vec(104, wr(A_CFG, 16'hA));
    @(negedge clk); rst_n = 1'b0; pr = '0; pg = '0; pb = '0;
    #1;
    check("R1 outputs after reset", {qr, qg, qb}, 30'd0);
    reg_addr = A_ST;   #1; check("R1 status after reset", {20'd0, reg_rdata}, 30'd0);
    reg_addr = A_CFG;  #1; check("R1 config after reset", {20'd0, reg_rdata}, 30'd7);
    reg_addr = A_CTRL; #1; check("R1 control after reset", {20'd0, reg_rdata}, 30'd0);
    reg_addr = A_IDX;  #1; check("R1 index after reset", {20'd0, reg_rdata}, 30'd0);
    @(negedge clk); rst_n = 1'b1;

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule